// File: doc/BRIEF.md
# Five-State Snooping Coherence Controller

This block holds the coherence state of every line in one private cache that sits on a shared snooping bus. Each line is tracked in one of five states: Invalid, Shared, Exclusive, Owned or Modified. Processor-side requests (read, write, claim ownership, evict, clean) are turned into the bus command this cache must issue and into the line's next state. Transactions from other caches observed on the bus (read, read-for-ownership, invalidate) are turned into a data-supply indication and a state change. Data storage, tag lookup, bus arbitration and memory sit outside the block.

The bus is modelled as answering in the same cycle a command is issued: the `bus_shared_i` and `bus_owned_i` responses are sampled in the cycle in which `bus_cmd_o` carries a command, and all state updates land on the following rising clock edge. A dirty line can be shared without a memory update by passing through the Owned state, and the duty to write it back always stays with exactly one holder. The state of the line addressed by `cpu_idx_i` is presented on `cpu_state_o` for the cache datapath.

Top module: `moesi_ctrl`

## Requirements
- R1: After reset every line is Invalid. State codes on `cpu_state_o`: 0 Invalid, 1 Shared, 2 Exclusive, 3 Owned, 4 Modified.
- R2: A read (op code 0) of an Invalid line issues bus command 1 (read) and ends in Exclusive when `bus_shared_i` is 0, in Shared when it is 1; a read of any valid line issues command 0 (none), changes nothing and ignores both response inputs.
- R3: A write (op code 1) always ends in Modified: from Invalid it issues command 2 (read-for-ownership), from Shared or Owned command 3 (invalidate), from Exclusive or Modified no command.
- R4: A claim (op code 2) from Invalid issues command 2 and from Shared command 3, ending in Modified when `bus_owned_i` is 1 and in Exclusive when it is 0; a claim from Owned issues command 3 and ends in Modified; from Exclusive or Modified it issues nothing and changes nothing.
- R5: An evict (op code 3) ends in Invalid; it issues command 4 (writeback) from Modified or Owned and no command from Exclusive, Shared or Invalid.
- R6: A clean (op code 4) from Modified issues command 4 and ends in Exclusive; from Owned it issues command 4 and ends in Shared; from any other state it issues nothing and changes nothing.
- R7: A snooped read (snoop op 0) of a Modified line asserts `snp_supply_o` and moves it to Owned; of an Owned line asserts `snp_supply_o` and keeps it Owned; of an Exclusive line moves it to Shared without supplying; Shared and Invalid lines neither supply nor change.
- R8: A snooped read-for-ownership (snoop op 1) or invalidate (snoop op 2) moves any line to Invalid, asserting `snp_supply_o` only when the line was Modified or Owned.
- R9: `snp_supply_o` is never asserted in a cycle without `snp_valid_i`.
- R10: When a processor request and a snoop name the same line in the same cycle, `cpu_ready_o` is 0, `bus_cmd_o` is 0 and only the snoop's transition is applied; requests on different lines are both applied in that cycle.
- R11: With `cpu_req_i` low, `bus_cmd_o` is 0, `cpu_ready_o` is 1 and no line changes state from the processor side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request valid |
| cpu_op_i | input | 3 | Processor op: 0 read, 1 write, 2 claim, 3 evict, 4 clean |
| cpu_idx_i | input | IDX_W | Line addressed by the processor |
| bus_shared_i | input | 1 | Bus response: another cache holds a copy |
| bus_owned_i | input | 1 | Bus response: another cache held the line dirty |
| snp_valid_i | input | 1 | Snooped transaction valid |
| snp_op_i | input | 2 | Snoop op: 0 read, 1 read-for-ownership, 2 invalidate |
| snp_idx_i | input | IDX_W | Line addressed by the snoop |
| cpu_ready_o | output | 1 | Processor request accepted this cycle |
| cpu_state_o | output | 3 | Current state of line `cpu_idx_i` |
| bus_cmd_o | output | 3 | Bus command: 0 none, 1 read, 2 read-for-ownership, 3 invalidate, 4 writeback |
| snp_supply_o | output | 1 | This cache drives the snooped line's data |

## Verification
Every cycle the assertions confirm that only legal state codes are stored, that dirty lines supply on every snoop while clean ones stay silent, that supply never appears without a snoop, that a stalled request drives no bus command, and that accepted writes, evicts and exclusive snoops land in Modified or Invalid on the next edge. The path-dependent outcomes only the directed scenarios show: the Shared-versus-Exclusive choice on a read miss, the claim that ends Modified because a dirty owner answered, the Owned line that stays Owned while supplying, clean-down from Owned to Shared, and the exact line that wins a same-cycle collision.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

  typedef enum logic [2:0] {
    ST_I = 3'd0,
    ST_S = 3'd1,
    ST_E = 3'd2,
    ST_O = 3'd3,
    ST_M = 3'd4
  } line_st_e;

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_CLAIM = 3'd2,
    OP_EVICT = 3'd3,
    OP_CLEAN = 3'd4
  } cpu_op_e;

  typedef enum logic [1:0] {
    SN_READ = 2'd0,
    SN_RDX  = 2'd1,
    SN_INV  = 2'd2
  } snp_op_e;

  typedef enum logic [2:0] {
    BC_NONE = 3'd0,
    BC_READ = 3'd1,
    BC_RDX  = 3'd2,
    BC_INV  = 3'd3,
    BC_WB   = 3'd4
  } bus_cmd_e;

endpackage

// File: rtl/moesi_cpu_next.sv
module moesi_cpu_next
  import moesi_pkg::*;
(
  input  line_st_e cur_i,
  input  cpu_op_e  op_i,
  input  logic     shared_i,
  input  logic     owned_i,
  output line_st_e nxt_o,
  output bus_cmd_e cmd_o
);

  always_comb begin
    nxt_o = cur_i;
    cmd_o = BC_NONE;
    case (op_i)
      OP_READ: begin
        if (cur_i == ST_I) begin
          cmd_o = BC_READ;
          nxt_o = shared_i ? ST_S : ST_E;
        end
      end
      OP_WRITE: begin
        nxt_o = ST_M;
        case (cur_i)
          ST_I:       cmd_o = BC_RDX;
          ST_S, ST_O: cmd_o = BC_INV;
          default:    cmd_o = BC_NONE;
        endcase
      end
      OP_CLAIM: begin
        case (cur_i)
          ST_I: begin
            cmd_o = BC_RDX;
            nxt_o = owned_i ? ST_M : ST_E;
          end
          ST_S: begin
            // a dirty previous owner hands its writeback duty to us
            cmd_o = BC_INV;
            nxt_o = owned_i ? ST_M : ST_E;
          end
          ST_O: begin
            cmd_o = BC_INV;
            nxt_o = ST_M;
          end
          default: ;
        endcase
      end
      OP_EVICT: begin
        nxt_o = ST_I;
        if (cur_i == ST_M || cur_i == ST_O) cmd_o = BC_WB;
      end
      OP_CLEAN: begin
        if (cur_i == ST_M) begin
          cmd_o = BC_WB;
          nxt_o = ST_E;
        end else if (cur_i == ST_O) begin
          cmd_o = BC_WB;
          nxt_o = ST_S;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/moesi_snoop_next.sv
module moesi_snoop_next
  import moesi_pkg::*;
(
  input  line_st_e cur_i,
  input  snp_op_e  op_i,
  output line_st_e nxt_o,
  output logic     supply_o
);

  logic dirty;
  assign dirty = (cur_i == ST_M) || (cur_i == ST_O);

  always_comb begin
    nxt_o    = cur_i;
    supply_o = 1'b0;
    case (op_i)
      SN_READ: begin
        supply_o = dirty;
        if (cur_i == ST_M)      nxt_o = ST_O;
        else if (cur_i == ST_E) nxt_o = ST_S;
      end
      SN_RDX, SN_INV: begin
        supply_o = dirty;
        nxt_o    = ST_I;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/moesi_line_array.sv
module moesi_line_array
  import moesi_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cpu_we_i,
  input  logic [IDX_W-1:0]         cpu_idx_i,
  input  line_st_e                 cpu_nxt_i,
  input  logic                     snp_we_i,
  input  logic [IDX_W-1:0]         snp_idx_i,
  input  line_st_e                 snp_nxt_i,
  output line_st_e [NUM_LINES-1:0] st_o
);

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
    line_st_e st_r;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_r <= ST_I;
      end else if (snp_we_i && snp_idx_i == MY_IDX) begin
        st_r <= snp_nxt_i;
      end else if (cpu_we_i && cpu_idx_i == MY_IDX) begin
        st_r <= cpu_nxt_i;
      end
    end

    assign st_o[g] = st_r;
  end

endmodule

// File: rtl/moesi_ctrl.sv
module moesi_ctrl
  import moesi_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpu_req_i,
  input  logic [2:0]       cpu_op_i,
  input  logic [IDX_W-1:0] cpu_idx_i,
  input  logic             bus_shared_i,
  input  logic             bus_owned_i,
  input  logic             snp_valid_i,
  input  logic [1:0]       snp_op_i,
  input  logic [IDX_W-1:0] snp_idx_i,
  output logic             cpu_ready_o,
  output logic [2:0]       cpu_state_o,
  output logic [2:0]       bus_cmd_o,
  output logic             snp_supply_o
);

  line_st_e [NUM_LINES-1:0] st_q;
  line_st_e cpu_cur, cpu_nxt, snp_cur, snp_nxt;
  bus_cmd_e cpu_cmd;
  logic     snp_sup, conflict, cpu_go;

  assign cpu_cur  = st_q[cpu_idx_i];
  assign snp_cur  = st_q[snp_idx_i];
  assign conflict = cpu_req_i && snp_valid_i && (cpu_idx_i == snp_idx_i);
  assign cpu_go   = cpu_req_i && !conflict;

  moesi_cpu_next u_cpu_next (
    .cur_i    (cpu_cur),
    .op_i     (cpu_op_e'(cpu_op_i)),
    .shared_i (bus_shared_i),
    .owned_i  (bus_owned_i),
    .nxt_o    (cpu_nxt),
    .cmd_o    (cpu_cmd)
  );

  moesi_snoop_next u_snp_next (
    .cur_i    (snp_cur),
    .op_i     (snp_op_e'(snp_op_i)),
    .nxt_o    (snp_nxt),
    .supply_o (snp_sup)
  );

  moesi_line_array #(
    .NUM_LINES (NUM_LINES),
    .IDX_W     (IDX_W)
  ) u_lines (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cpu_we_i  (cpu_go),
    .cpu_idx_i (cpu_idx_i),
    .cpu_nxt_i (cpu_nxt),
    .snp_we_i  (snp_valid_i),
    .snp_idx_i (snp_idx_i),
    .snp_nxt_i (snp_nxt),
    .st_o      (st_q)
  );

  assign cpu_ready_o  = !conflict;
  assign cpu_state_o  = cpu_cur;
  assign bus_cmd_o    = cpu_go ? cpu_cmd : BC_NONE;
  assign snp_supply_o = snp_valid_i && snp_sup;

endmodule

// File: rtl/moesi_ctrl_chk.sv
module moesi_ctrl_chk
  import moesi_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = 3
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     cpu_req_i,
  input logic [2:0]               cpu_op_i,
  input logic [IDX_W-1:0]         cpu_idx_i,
  input logic                     snp_valid_i,
  input logic [1:0]               snp_op_i,
  input logic [IDX_W-1:0]         snp_idx_i,
  input logic                     cpu_ready_o,
  input logic [2:0]               bus_cmd_o,
  input logic                     snp_supply_o,
  input line_st_e [NUM_LINES-1:0] st_q
);

  logic [IDX_W-1:0] cidx_d, sidx_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cidx_d <= '0;
      sidx_d <= '0;
    end else begin
      cidx_d <= cpu_idx_i;
      sidx_d <= snp_idx_i;
    end
  end

  // R1: only the five defined codes are ever stored
  always_comb begin
    if (rst_ni) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        a_r1_state_legal: assert (st_q[i] inside {ST_I, ST_S, ST_E, ST_O, ST_M});
      end
    end
  end

  a_r9_supply_needs_snoop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snp_valid_i |-> !snp_supply_o);

  a_r7_clean_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i && (st_q[snp_idx_i] inside {ST_I, ST_S, ST_E}) |-> !snp_supply_o);

  a_r8_dirty_supplies: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i && snp_op_i <= 2'd2 && (st_q[snp_idx_i] inside {ST_O, ST_M})
      |-> snp_supply_o);

  a_r8_excl_snoop_invalidates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i && (snp_op_i == 2'd1 || snp_op_i == 2'd2) |=> st_q[sidx_d] == ST_I);

  a_r10_stall_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_ready_o |-> bus_cmd_o == 3'd0);

  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_req_i |-> bus_cmd_o == 3'd0 && cpu_ready_o);

  a_r3_write_ends_m: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && cpu_ready_o && cpu_op_i == 3'd1 && !(snp_valid_i && snp_idx_i == cpu_idx_i)
      |=> st_q[cidx_d] == ST_M);

  a_r5_evict_ends_i: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && cpu_ready_o && cpu_op_i == 3'd3 |=> st_q[cidx_d] == ST_I);

endmodule

bind moesi_ctrl moesi_ctrl_chk #(
  .NUM_LINES (NUM_LINES),
  .IDX_W     (IDX_W)
) u_chk (.*);

// File: tb/moesi_ctrl_tb_top.sv
module moesi_ctrl_tb_top;

  localparam int NL = 8;
  localparam int IW = 3;

  localparam logic [2:0] S_I = 3'd0, S_S = 3'd1, S_E = 3'd2, S_O = 3'd3, S_M = 3'd4;
  localparam logic [2:0] O_RD = 3'd0, O_WR = 3'd1, O_CL = 3'd2, O_EV = 3'd3, O_CN = 3'd4;
  localparam logic [1:0] N_RD = 2'd0, N_RDX = 2'd1, N_INV = 2'd2;
  localparam logic [2:0] C_NO = 3'd0, C_RD = 3'd1, C_RDX = 3'd2, C_INV = 3'd3, C_WB = 3'd4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req = 1'b0;
  logic [2:0]    cpu_op = 3'd0;
  logic [IW-1:0] cpu_idx = '0;
  logic          bus_shared = 1'b0;
  logic          bus_owned = 1'b0;
  logic          snp_valid = 1'b0;
  logic [1:0]    snp_op = 2'd0;
  logic [IW-1:0] snp_idx = '0;
  logic          cpu_ready;
  logic [2:0]    cpu_state;
  logic [2:0]    bus_cmd;
  logic          snp_supply;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [2:0] last_cmd;
  logic       last_sup;

  always #5 clk = ~clk;

  moesi_ctrl #(.NUM_LINES(NL)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cpu_req_i    (cpu_req),
    .cpu_op_i     (cpu_op),
    .cpu_idx_i    (cpu_idx),
    .bus_shared_i (bus_shared),
    .bus_owned_i  (bus_owned),
    .snp_valid_i  (snp_valid),
    .snp_op_i     (snp_op),
    .snp_idx_i    (snp_idx),
    .cpu_ready_o  (cpu_ready),
    .cpu_state_o  (cpu_state),
    .bus_cmd_o    (bus_cmd),
    .snp_supply_o (snp_supply)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one accepted processor cycle; command captured mid-cycle
  task automatic cpu_cycle(input logic [IW-1:0] idx, input logic [2:0] op,
                           input logic sh, input logic ow);
    @(negedge clk);
    cpu_req = 1'b1; cpu_op = op; cpu_idx = idx; bus_shared = sh; bus_owned = ow;
    #1 last_cmd = bus_cmd;
    @(negedge clk);
    cpu_req = 1'b0; bus_shared = 1'b0; bus_owned = 1'b0;
  endtask

  task automatic snp_cycle(input logic [IW-1:0] idx, input logic [1:0] op);
    @(negedge clk);
    snp_valid = 1'b1; snp_op = op; snp_idx = idx;
    #1 last_sup = snp_supply;
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic peek(input logic [IW-1:0] idx, output logic [2:0] st);
    cpu_req = 1'b0; cpu_idx = idx;
    #1 st = cpu_state;
  endtask

  // drive a line from any state to the requested one
  task automatic make(input logic [IW-1:0] idx, input logic [2:0] st);
    cpu_cycle(idx, O_EV, 1'b0, 1'b0);
    case (st)
      S_S: cpu_cycle(idx, O_RD, 1'b1, 1'b0);
      S_E: cpu_cycle(idx, O_RD, 1'b0, 1'b0);
      S_M: cpu_cycle(idx, O_WR, 1'b0, 1'b0);
      S_O: begin cpu_cycle(idx, O_WR, 1'b0, 1'b0); snp_cycle(idx, N_RD); end
      default: ;
    endcase
  endtask

  task automatic do_cpu(input string req, input logic [IW-1:0] idx, input logic [2:0] op,
                        input logic sh, input logic ow,
                        input logic [2:0] exp_cmd, input logic [2:0] exp_st);
    logic [2:0] st;
    cpu_cycle(idx, op, sh, ow);
    chk(req, "bus_cmd", last_cmd, exp_cmd);
    peek(idx, st);
    chk(req, "state", st, exp_st);
  endtask

  task automatic do_snp(input string req, input logic [IW-1:0] idx, input logic [1:0] op,
                        input logic exp_sup, input logic [2:0] exp_st);
    logic [2:0] st;
    snp_cycle(idx, op);
    chk(req, "supply", last_sup, exp_sup);
    peek(idx, st);
    chk(req, "state", st, exp_st);
  endtask

  task automatic t_reset;
    logic [2:0] st;
    for (int i = 0; i < NL; i++) begin
      peek(IW'(i), st);
      chk("R1", "reset state", st, S_I);
    end
  endtask

  task automatic t_read;
    make(3'd0, S_I);
    do_cpu("R2", 3'd0, O_RD, 1'b0, 1'b0, C_RD, S_E);
    make(3'd1, S_I);
    do_cpu("R2", 3'd1, O_RD, 1'b1, 1'b1, C_RD, S_S);
    do_cpu("R2", 3'd0, O_RD, 1'b1, 1'b1, C_NO, S_E);
    make(3'd2, S_O);
    do_cpu("R2", 3'd2, O_RD, 1'b0, 1'b0, C_NO, S_O);
  endtask

  task automatic t_write;
    make(3'd2, S_I);
    do_cpu("R3", 3'd2, O_WR, 1'b0, 1'b0, C_RDX, S_M);
    make(3'd0, S_E);
    do_cpu("R3", 3'd0, O_WR, 1'b0, 1'b0, C_NO, S_M);
    make(3'd1, S_S);
    do_cpu("R3", 3'd1, O_WR, 1'b1, 1'b0, C_INV, S_M);
    do_cpu("R3", 3'd2, O_WR, 1'b0, 1'b0, C_NO, S_M);
    make(3'd3, S_O);
    do_cpu("R3", 3'd3, O_WR, 1'b0, 1'b0, C_INV, S_M);
  endtask

  task automatic t_claim;
    make(3'd4, S_I);
    do_cpu("R4", 3'd4, O_CL, 1'b0, 1'b0, C_RDX, S_E);
    make(3'd4, S_I);
    do_cpu("R4", 3'd4, O_CL, 1'b0, 1'b1, C_RDX, S_M);
    make(3'd5, S_S);
    do_cpu("R4", 3'd5, O_CL, 1'b0, 1'b1, C_INV, S_M);
    make(3'd6, S_S);
    do_cpu("R4", 3'd6, O_CL, 1'b1, 1'b0, C_INV, S_E);
    make(3'd7, S_O);
    do_cpu("R4", 3'd7, O_CL, 1'b0, 1'b0, C_INV, S_M);
    do_cpu("R4", 3'd4, O_CL, 1'b0, 1'b1, C_NO, S_M);
    do_cpu("R4", 3'd6, O_CL, 1'b0, 1'b1, C_NO, S_E);
  endtask

  task automatic t_evict;
    make(3'd0, S_M);
    do_cpu("R5", 3'd0, O_EV, 1'b0, 1'b0, C_WB, S_I);
    make(3'd1, S_O);
    do_cpu("R5", 3'd1, O_EV, 1'b0, 1'b0, C_WB, S_I);
    make(3'd2, S_E);
    do_cpu("R5", 3'd2, O_EV, 1'b0, 1'b0, C_NO, S_I);
    make(3'd3, S_S);
    do_cpu("R5", 3'd3, O_EV, 1'b0, 1'b0, C_NO, S_I);
    do_cpu("R5", 3'd3, O_EV, 1'b0, 1'b0, C_NO, S_I);
  endtask

  task automatic t_clean;
    make(3'd0, S_M);
    do_cpu("R6", 3'd0, O_CN, 1'b0, 1'b0, C_WB, S_E);
    make(3'd1, S_O);
    do_cpu("R6", 3'd1, O_CN, 1'b0, 1'b0, C_WB, S_S);
    do_cpu("R6", 3'd0, O_CN, 1'b0, 1'b0, C_NO, S_E);
    do_cpu("R6", 3'd1, O_CN, 1'b0, 1'b0, C_NO, S_S);
  endtask

  task automatic t_snoop_read;
    make(3'd0, S_M);
    do_snp("R7", 3'd0, N_RD, 1'b1, S_O);
    do_snp("R7", 3'd0, N_RD, 1'b1, S_O);
    make(3'd1, S_E);
    do_snp("R7", 3'd1, N_RD, 1'b0, S_S);
    do_snp("R7", 3'd1, N_RD, 1'b0, S_S);
    make(3'd2, S_I);
    do_snp("R7", 3'd2, N_RD, 1'b0, S_I);
  endtask

  task automatic t_snoop_excl;
    make(3'd0, S_M);
    do_snp("R8", 3'd0, N_RDX, 1'b1, S_I);
    make(3'd1, S_O);
    do_snp("R8", 3'd1, N_INV, 1'b1, S_I);
    make(3'd2, S_E);
    do_snp("R8", 3'd2, N_RDX, 1'b0, S_I);
    make(3'd3, S_S);
    do_snp("R8", 3'd3, N_INV, 1'b0, S_I);
    do_snp("R8", 3'd3, N_RDX, 1'b0, S_I);
  endtask

  task automatic t_supply_idle;
    logic sup;
    make(3'd5, S_M);
    @(negedge clk);
    snp_valid = 1'b0; snp_idx = 3'd5; snp_op = N_RD;
    #1 sup = snp_supply;
    chk("R9", "supply without snoop", sup, 0);
  endtask

  task automatic t_conflict;
    logic [2:0] st;
    make(3'd0, S_E);
    @(negedge clk);
    cpu_req = 1'b1; cpu_op = O_WR; cpu_idx = 3'd0;
    snp_valid = 1'b1; snp_op = N_RDX; snp_idx = 3'd0;
    #1;
    chk("R10", "ready on collision", cpu_ready, 0);
    chk("R10", "bus_cmd on collision", bus_cmd, C_NO);
    @(negedge clk);
    cpu_req = 1'b0; snp_valid = 1'b0;
    peek(3'd0, st);
    chk("R10", "snoop wins", st, S_I);
    make(3'd1, S_E);
    make(3'd2, S_M);
    @(negedge clk);
    cpu_req = 1'b1; cpu_op = O_WR; cpu_idx = 3'd1;
    snp_valid = 1'b1; snp_op = N_RD; snp_idx = 3'd2;
    #1;
    chk("R10", "ready distinct lines", cpu_ready, 1);
    chk("R10", "supply distinct lines", snp_supply, 1);
    @(negedge clk);
    cpu_req = 1'b0; snp_valid = 1'b0;
    peek(3'd1, st);
    chk("R10", "cpu side applied", st, S_M);
    peek(3'd2, st);
    chk("R10", "snoop side applied", st, S_O);
  endtask

  task automatic t_idle;
    logic [2:0] st;
    make(3'd3, S_S);
    @(negedge clk);
    cpu_req = 1'b0; cpu_op = O_WR; cpu_idx = 3'd3; bus_owned = 1'b1;
    #1;
    chk("R11", "idle bus_cmd", bus_cmd, C_NO);
    chk("R11", "idle ready", cpu_ready, 1);
    @(negedge clk);
    @(negedge clk);
    bus_owned = 1'b0;
    peek(3'd3, st);
    chk("R11", "idle state kept", st, S_S);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_read();
    t_write();
    t_claim();
    t_evict();
    t_clean();
    t_snoop_read();
    t_snoop_excl();
    t_supply_idle();
    t_conflict();
    t_idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule